// File: doc/BRIEF.md
# Breaker Failure Timing Logic

This block decides, on a millisecond tick, whether a circuit breaker has failed to clear a fault after being told to open. It has two initiate paths. A three-pole path takes three initiate inputs and is supervised by either the phase or the neutral fault-detector flag. A single-pole path takes two initiate inputs and is supervised by the phase flag alone. Each path has its own programmable delay timer. When a delay timer expires while its supervising detector is picked up, all three backup-trip outputs close.

The first initiate starts a shared control window. The window latches every initiate that arrives while it is open, so a brief initiate pulse keeps its delay timer running. The window also bounds how long a backup trip can follow from that initiation. A trip, or the end of the window, clears the latches and timers and locks out new initiations. The lockout lifts once every initiate input has been inactive for one tick. The block checks its settings and refuses to trip if the window is not longer than both delays.

All state advances only on clock edges where the tick enable is high. Reset is synchronous and active high.

Top module: `bf_timing_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, trip_o is 3'b000. All timers, latches and the lockout are cleared.
- R2: An initiate is accepted on a tick k when any three-pole initiate input is high. If the phase or the neutral detector is high on tick k+1+dly_3p_i, all three trip_o bits become 1 after that tick's edge. The trip_o bits are always equal.
- R3: An initiate input high for only one tick is latched. It still produces the trip of R2 at the same tick.
- R4: The control window opened on tick k closes on tick k+1+win_i. No trip is produced on that tick or later from that initiation, including when a path latched late expires on the closing tick itself.
- R5: A single-pole initiate accepted on tick k, with the phase detector high on tick k+1+dly_1p_i, drives trip_o to 3'b111.
- R6: The neutral detector alone never lets the single-pole path trip.
- R7: A delay setting of 0 makes that path expire on the first tick after it latched.
- R8: set_err_o is 1 exactly when win_i <= dly_3p_i or win_i <= dly_1p_i. While it is 1, no new trip is produced.
- R9: A trip holds while either detector is high. It releases on the first tick on which both detectors are low.
- R10: After a trip or a window close, initiates are ignored until a tick is seen with all five initiate inputs low.
- R11: On edges with tick_en low, no timer, latch or output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Millisecond tick enable |
| bfi_3p_i | input | N_INIT_3P | Three-pole initiate inputs |
| bfi_1p_i | input | N_INIT_1P | Single-pole initiate inputs |
| fd_phase_i | input | 1 | Phase fault detector picked up |
| fd_neutral_i | input | 1 | Neutral fault detector picked up |
| dly_3p_i | input | TMR_W | Three-pole delay setting, ticks |
| dly_1p_i | input | TMR_W | Single-pole delay setting, ticks |
| win_i | input | TMR_W | Control-window setting, ticks |
| trip_o | output | N_TRIP | Backup-trip outputs |
| set_err_o | output | 1 | Window setting not longer than both delays |

## Verification
The critical coincidence is a delay expiry landing on the same tick as the window close. The bench opens the window with a single-pole initiate that only the neutral detector supervises, so that path can never trip. It then latches a three-pole initiate late enough that its expiry falls exactly on the closing tick, and expects no trip. A control run, one tick earlier, expects the trip. The lockout release and a fresh initiation are also driven in adjacent ticks. A behavioural model judges every clock edge, including randomly timed settings, detectors and gapped ticks.

// File: rtl/bf_pkg.sv
package bf_pkg;

    localparam int NPATH  = 2;
    localparam int IDX_3P = 0;
    localparam int IDX_1P = 1;

    typedef enum logic [1:0] {
        WIN_IDLE = 2'd0,
        WIN_OPEN = 2'd1,
        WIN_LOCK = 2'd2
    } win_state_t;

    typedef struct packed {
        logic latched;
        logic expired;
    } path_stat_t;

    // Which detectors may enable a trip on a given path.
    function automatic logic path_supervised(input int idx, input logic fd_ph, input logic fd_nt);
        if (idx == IDX_3P) return fd_ph | fd_nt;
        return fd_ph;
    endfunction

endpackage

// File: rtl/bf_delay_path.sv
module bf_delay_path
    import bf_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             req,
    input  logic             arm,
    input  logic             clear,
    input  logic [TMR_W-1:0] dly_set,
    output path_stat_t       stat
);

    logic             lat_q;
    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= 1'b0;
            cnt_q <= '0;
        end else if (tick) begin
            if (clear) begin
                lat_q <= 1'b0;
                cnt_q <= '0;
            end else if (!lat_q && arm && req) begin
                lat_q <= 1'b1;
                cnt_q <= '0;
            end else if (lat_q && (cnt_q < dly_set)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        stat.latched = lat_q;
        stat.expired = (cnt_q >= dly_set);
    end

endmodule

// File: rtl/bf_window_ctrl.sv
module bf_window_ctrl
    import bf_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             any_req,
    input  logic             trip_fire,
    input  logic [TMR_W-1:0] win_set,
    output logic             win_open,
    output logic             win_done,
    output logic             start,
    output logic             close
);

    win_state_t       st_q;
    logic [TMR_W-1:0] wcnt_q;

    assign win_open = (st_q == WIN_OPEN);
    assign win_done = win_open && (wcnt_q >= win_set);
    assign start    = tick && (st_q == WIN_IDLE) && any_req;
    assign close    = tick && win_open && (win_done || trip_fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WIN_IDLE;
            wcnt_q <= '0;
        end else if (tick) begin
            unique case (st_q)
                WIN_IDLE: begin
                    if (any_req) begin
                        st_q   <= WIN_OPEN;
                        wcnt_q <= '0;
                    end
                end
                WIN_OPEN: begin
                    if (win_done || trip_fire) begin
                        st_q   <= WIN_LOCK;
                        wcnt_q <= '0;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                WIN_LOCK: begin
                    if (!any_req) st_q <= WIN_IDLE;
                end
                default: st_q <= WIN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bf_trip_latch.sv
module bf_trip_latch #(
    parameter int N_TRIP = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              fire,
    input  logic              fd_any,
    output logic [N_TRIP-1:0] trip
);

    // One register per output so each contact has its own driver.
    for (genvar g = 0; g < N_TRIP; g++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) begin
                trip[g] <= 1'b0;
            end else if (tick) begin
                if (fire)         trip[g] <= 1'b1;
                else if (!fd_any) trip[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bf_timing_top.sv
module bf_timing_top
    import bf_pkg::*;
#(
    parameter int TMR_W     = 16,
    parameter int N_INIT_3P = 3,
    parameter int N_INIT_1P = 2,
    parameter int N_TRIP    = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic [N_INIT_3P-1:0] bfi_3p_i,
    input  logic [N_INIT_1P-1:0] bfi_1p_i,
    input  logic                 fd_phase_i,
    input  logic                 fd_neutral_i,
    input  logic [TMR_W-1:0]     dly_3p_i,
    input  logic [TMR_W-1:0]     dly_1p_i,
    input  logic [TMR_W-1:0]     win_i,
    output logic [N_TRIP-1:0]    trip_o,
    output logic                 set_err_o
);

    logic             path_req  [NPATH];
    logic [TMR_W-1:0] path_dly  [NPATH];
    path_stat_t       path_stat [NPATH];
    logic [NPATH-1:0] path_hit;

    logic any_req, win_open, win_done, start, close, arm, trip_fire, fd_any;

    assign path_req[IDX_3P] = |bfi_3p_i;
    assign path_req[IDX_1P] = |bfi_1p_i;
    assign path_dly[IDX_3P] = dly_3p_i;
    assign path_dly[IDX_1P] = dly_1p_i;

    assign any_req   = path_req[IDX_3P] | path_req[IDX_1P];
    assign fd_any    = fd_phase_i | fd_neutral_i;
    assign set_err_o = (win_i <= dly_3p_i) || (win_i <= dly_1p_i);
    assign arm       = start || (win_open && !win_done);

    bf_window_ctrl #(.TMR_W(TMR_W)) u_win (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_en),
        .any_req   (any_req),
        .trip_fire (trip_fire),
        .win_set   (win_i),
        .win_open  (win_open),
        .win_done  (win_done),
        .start     (start),
        .close     (close)
    );

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        bf_delay_path #(.TMR_W(TMR_W)) u_path (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick_en),
            .req     (path_req[p]),
            .arm     (arm),
            .clear   (close),
            .dly_set (path_dly[p]),
            .stat    (path_stat[p])
        );
        assign path_hit[p] = path_stat[p].latched && path_stat[p].expired
                             && path_supervised(p, fd_phase_i, fd_neutral_i);
    end

    assign trip_fire = tick_en && win_open && !win_done && !set_err_o && (|path_hit);

    bf_trip_latch #(.N_TRIP(N_TRIP)) u_trip (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_en),
        .fire   (trip_fire),
        .fd_any (fd_any),
        .trip   (trip_o)
    );

endmodule

// File: rtl/bf_timing_chk.sv
module bf_timing_chk #(
    parameter int N_TRIP = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              fd_phase_i,
    input logic              fd_neutral_i,
    input logic [N_TRIP-1:0] trip_o,
    input logic              set_err_o
);

    p_trip_uniform_r2: assert property (@(posedge clk) disable iff (rst)
        (trip_o == '0) || (trip_o == '1));

    p_rise_needs_fd_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(trip_o[0]) |-> $past(fd_phase_i || fd_neutral_i));

    p_err_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        (set_err_o && !trip_o[0]) |=> !trip_o[0]);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (trip_o[0] && (fd_phase_i || fd_neutral_i)) |=> trip_o[0]);

    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(trip_o[0]) |-> $past(tick_en && !fd_phase_i && !fd_neutral_i));

    p_freeze_r11: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(trip_o));

endmodule

bind bf_timing_top bf_timing_chk #(.N_TRIP(N_TRIP)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_en      (tick_en),
    .fd_phase_i   (fd_phase_i),
    .fd_neutral_i (fd_neutral_i),
    .trip_o       (trip_o),
    .set_err_o    (set_err_o)
);

// File: tb/bf_timing_top_tb_top.sv
module bf_timing_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic [2:0]  bfi3 = '0;
    logic [1:0]  bfi1 = '0;
    logic        fdp = 1'b0, fdn = 1'b0;
    logic [15:0] d3 = 16'd3, d1 = 16'd2, w = 16'd8;
    logic [2:0]  trip;
    logic        serr;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    bf_timing_top dut_i (
        .clk(clk), .rst(rst), .tick_en(tick),
        .bfi_3p_i(bfi3), .bfi_1p_i(bfi1),
        .fd_phase_i(fdp), .fd_neutral_i(fdn),
        .dly_3p_i(d3), .dly_1p_i(d1), .win_i(w),
        .trip_o(trip), .set_err_o(serr)
    );

    // Behavioural reference: 0 idle, 1 window open, 2 locked out
    int m_st = 0, m_wcnt = 0, m_c3 = 0, m_c1 = 0;
    bit m_l3 = 0, m_l1 = 0, m_trip = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_wcnt = 0; m_c3 = 0; m_c1 = 0;
            m_l3 = 0; m_l1 = 0; m_trip = 0;
        end else if (tick) begin
            bit bad, done, e3, e1, fire, a3, a1;
            bad  = !((w > d3) && (w > d1));
            a3   = |bfi3;
            a1   = |bfi1;
            done = (m_st == 1) && (m_wcnt >= int'(w));
            e3   = m_l3 && (m_c3 >= int'(d3));
            e1   = m_l1 && (m_c1 >= int'(d1));
            fire = (m_st == 1) && !done && !bad && ((e3 && (fdp || fdn)) || (e1 && fdp));
            if (fire) m_trip = 1;
            else if (m_trip && !fdp && !fdn) m_trip = 0;
            if (m_st == 1 && (done || fire)) begin
                m_st = 2; m_wcnt = 0; m_l3 = 0; m_l1 = 0; m_c3 = 0; m_c1 = 0;
            end else if (m_st == 1) begin
                m_wcnt++;
                if (!m_l3 && a3) begin m_l3 = 1; m_c3 = 0; end
                else if (m_l3 && m_c3 < int'(d3)) m_c3++;
                if (!m_l1 && a1) begin m_l1 = 1; m_c1 = 0; end
                else if (m_l1 && m_c1 < int'(d1)) m_c1++;
            end else if (m_st == 0 && (a3 || a1)) begin
                m_st = 1; m_wcnt = 0;
                m_l3 = a3; m_c3 = 0; m_l1 = a1; m_c1 = 0;
            end else if (m_st == 2 && !a3 && !a1) begin
                m_st = 0;
            end
        end
    end

    // Per-clock comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (!finished) begin
            bit exp_err;
            exp_err = !((w > d3) && (w > d1));
            checks++;
            if (trip !== {3{m_trip}}) begin
                failures++;
                $display("FAIL R2 model trip act=%b exp=%b t=%0t", trip, {3{m_trip}}, $time);
            end
            checks++;
            if (serr !== exp_err) begin
                failures++;
                $display("FAIL R8 model set_err act=%b exp=%b t=%0t", serr, exp_err, $time);
            end
        end
    end

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet();
        bfi3 = '0; bfi1 = '0; fdp = 0; fdn = 0;
        wait_n(3);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wait_n(3);
        chk("R1 trip in reset", trip, 3'b000);
        rst = 0;
        wait_n(1);
        chk("R1 trip after reset", trip, 3'b000);

        // R2 neutral supervision on three-pole path, R9 hold/release
        fdn = 1; bfi3 = 3'b010;
        wait_n(4); chk("R2 before expiry", trip, 3'b000);
        wait_n(1); chk("R2 at expiry", trip, 3'b111);
        bfi3 = '0;
        wait_n(3); chk("R9 hold with detector", trip, 3'b111);
        fdn = 0;
        wait_n(1); chk("R9 release", trip, 3'b000);
        quiet();

        // R3 single-tick pulse latched
        fdp = 1; bfi3 = 3'b001;
        wait_n(1); bfi3 = '0;
        wait_n(3); chk("R3 before expiry", trip, 3'b000);
        wait_n(1); chk("R3 pulse trips", trip, 3'b111);
        quiet();

        // R6 neutral alone on single-pole path
        fdn = 1; bfi1 = 2'b01;
        wait_n(12); chk("R6 neutral no trip", trip, 3'b000);
        // R10 lockout while initiate held
        fdp = 1;
        wait_n(5); chk("R10 locked out", trip, 3'b000);
        bfi1 = '0;
        wait_n(1); bfi1 = 2'b10;
        wait_n(3); chk("R5 before expiry", trip, 3'b000);
        wait_n(1); chk("R5 single-pole trip", trip, 3'b111);
        quiet();

        // R4 window expiry then detector
        bfi3 = 3'b100;
        wait_n(12); fdp = 1;
        wait_n(3); chk("R4 no trip after window", trip, 3'b000);
        quiet();

        // R4 coincidence: late three-pole expiry on closing tick
        d3 = 2; d1 = 1; w = 5;
        fdn = 1; bfi1 = 2'b01;
        wait_n(3); bfi3 = 3'b001;
        wait_n(5); chk("R4 expiry on closing tick", trip, 3'b000);
        quiet();
        fdn = 1; bfi1 = 2'b01;
        wait_n(2); bfi3 = 3'b001;
        wait_n(5); chk("R2 expiry one tick before close", trip, 3'b111);
        quiet();

        // R7 zero delay
        d3 = 0; d1 = 2; w = 8;
        fdp = 1; bfi3 = 3'b001;
        wait_n(1); chk("R7 initiation tick", trip, 3'b000);
        wait_n(1); chk("R7 zero delay trip", trip, 3'b111);
        quiet();

        // R8 setting error
        d3 = 3; d1 = 8; w = 8;
        wait_n(1); chk("R8 flag set", {2'b00, serr}, 3'b001);
        fdp = 1; bfi1 = 2'b01;
        wait_n(12); chk("R8 trip blocked", trip, 3'b000);
        quiet();
        d1 = 2;
        wait_n(1); chk("R8 flag clear", {2'b00, serr}, 3'b000);

        // R11 no tick, no change
        tick = 0; fdp = 1; bfi3 = 3'b001;
        wait_n(10); chk("R11 frozen", trip, 3'b000);
        tick = 1;
        wait_n(4); chk("R11 before expiry", trip, 3'b000);
        wait_n(1); chk("R11 trip after ticks resume", trip, 3'b111);
        quiet();

        // Random phase against the model
        for (int i = 0; i < 4000; i++) begin
            if (i % 300 == 0) begin
                d3 = 16'($urandom_range(0, 5));
                d1 = 16'($urandom_range(0, 5));
                w  = 16'($urandom_range(0, 10));
            end
            if ($urandom_range(0, 9) == 0) bfi3 = 3'($urandom);
            if ($urandom_range(0, 9) == 0) bfi1 = 2'($urandom);
            if ($urandom_range(0, 14) == 0) fdp = ~fdp;
            if ($urandom_range(0, 14) == 0) fdn = ~fdn;
            tick = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 999) == 0) rst = 1; else rst = 0;
            wait_n(1);
        end
        rst = 0; tick = 1;
        quiet();
        finish_run();
    end

endmodule